// File: doc/BRIEF.md
# Random Number Peripheral Register Controller

This block holds the control and status logic of a random number peripheral. A small bus with four word registers lets software enable generation, arm an interrupt, and set noise-source configuration. It also drives a two-phase conditioning reset, unlocks and writes a health-test setting, and drains a four-word output buffer one read at a time. A 32-bit LFSR stands in for the physical noise source. Two fault inputs let a test inject a seed failure or a clock failure.

The buffer refills only while it is empty, generation is enabled, no seed error is present and the conditioning sequencer is idle. After a seed fault, data stays blocked until software runs a full conditioning reset (set the bit, wait for it to read back set, clear it, wait for it to read back clear). A clock fault only raises a flag, and generation continues.

Top module: `rng_regctl`

## Requirements
- R1: Registers sit at word address 0 (control), 1 (status), 2 (data) and 3 (health test). Read data appears on `bus_rdata` in the cycle after the access. After reset, control, status and data read 0, and the health-test register holds 0x0000_72A5.
- R2: Control layout: bit0 generate enable, bit1 interrupt enable, bit2 clock-check disable, bit3 conditioning reset, bits[17:4] configuration. The configuration is captured only by a control write that has bit3 set. Otherwise the written configuration is ignored.
- R3: After bit3 is written 1, it reads back 0 until conditioning has been entered (5 cycles). It then reads 1 while conditioning runs and for 5 cycles after bit3 is written 0. After that it reads 0.
- R4: The source is a right-shifting Galois LFSR with polynomial mask 0x80200003 and seed 0x1ACEB00C. A refill takes 16 steps, one per cycle, and captures the next-state value on every 4th step. Ready (status bit0) is set on the 16th step edge after generation was enabled into an empty buffer.
- R5: Four data reads return the buffered words in capture order, and ready clears after the fourth. A data read while ready is 0 returns 0 and removes nothing.
- R6: No word held in a ready buffer is zero.
- R7: `irq_o` is high exactly when interrupt enable is set and any of status bits 0, 1 or 2 is set.
- R8: Writing 0x17590ABC to address 3 unlocks only the next bus access, whatever its address. A read of address 3 without the unlock returns 0. A write without the unlock is ignored.
- R9: An unlocked health-test write takes effect only while conditioning is active. Otherwise it is ignored.
- R10: With bit2 clear, a clock fault sets status bit1 in the next cycle and generation goes on. A status write with bit1 = 0 clears the flag, and a status write with bit1 = 1 leaves it set. With bit2 set, a clock fault is ignored.
- R11: A seed fault sets status bit2 (seed flag) and bit3 (seed now), flushes the buffer and clears ready in the next cycle. No refill happens while bit3 is set.
- R12: Entering conditioning clears the seed flag. Leaving conditioning clears seed-now, and refilling then resumes from the LFSR state where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Bus access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after a read |
| irq_o | output | 1 | Interrupt request |
| seed_fault_i | input | 1 | Injects a seed failure |
| clk_fault_i | input | 1 | Injects a clock failure |

## Verification
A register read is captured at the access edge, so the bench drives on the falling edge and samples `bus_rdata` on the next falling edge. A fault flag is due at the edge that samples the fault input, so the status read that follows shows it. Ready is due exactly 16 edges after the enabling write, and the bench samples the interrupt line at 15 and at 16 falling edges to pin that down. The conditioning handshake takes several cycles, so the bench checks the first readback for 0 and then polls with a bounded count. Each refill after that is awaited by polling status with a limit, and the bench counts any timeout as a failure.

// File: rtl/rng_regctl_pkg.sv
// Shared constants and types of the random number register controller.
// Assumes a word-addressed bus with four registers.
package rng_regctl_pkg;
    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_STAT = 2'd1;
    localparam logic [1:0] A_DATA = 2'd2;
    localparam logic [1:0] A_HTST = 2'd3;

    localparam int unsigned CB_EN   = 0;
    localparam int unsigned CB_IE   = 1;
    localparam int unsigned CB_CED  = 2;
    localparam int unsigned CB_COND = 3;
    localparam int unsigned CFG_LSB = 4;
    localparam int unsigned CFG_W   = 14;

    localparam int unsigned SB_CLK  = 1;

    typedef enum logic [1:0] {
        CS_IDLE,
        CS_ENTER,
        CS_ACTIVE,
        CS_LEAVE
    } cond_state_e;
endpackage

// File: rtl/rng_cond_fsm.sv
// Conditioning-reset sequencer. Enters conditioning LAT+1 cycles after the
// request rises and leaves LAT+1 cycles after it falls. Assumes LAT >= 1.
module rng_cond_fsm
    import rng_regctl_pkg::*;
#(
    parameter int unsigned LAT = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_i,
    output cond_state_e state_o,
    output logic        rb_o,
    output logic        active_o,
    output logic        done_o
);
    localparam int unsigned CW = $clog2(LAT + 1);

    cond_state_e   state_q;
    logic [CW-1:0] cnt_q;

    // Walk the enter / active / leave phases with a latency counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CS_IDLE;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                CS_IDLE: if (req_i) begin
                    state_q <= CS_ENTER;
                    cnt_q   <= CW'(LAT - 1);
                end
                CS_ENTER: if (cnt_q == '0) state_q <= CS_ACTIVE;
                          else cnt_q <= cnt_q - 1'b1;
                CS_ACTIVE: if (!req_i) begin
                    state_q <= CS_LEAVE;
                    cnt_q   <= CW'(LAT - 1);
                end
                CS_LEAVE: if (cnt_q == '0) state_q <= CS_IDLE;
                          else cnt_q <= cnt_q - 1'b1;
                default: state_q <= CS_IDLE;
            endcase
        end
    end

    assign state_o  = state_q;
    assign rb_o     = (state_q == CS_ACTIVE) || (state_q == CS_LEAVE);
    assign active_o = (state_q == CS_ACTIVE);
    assign done_o   = (state_q == CS_LEAVE) && (cnt_q == '0);
endmodule

// File: rtl/rng_entropy_src.sv
// Stand-in entropy source: a Galois LFSR stepped once per cycle while a
// refill runs. A refill starts when the buffer is empty and takes
// FILL_CYCLES steps, pushing one word every FILL_CYCLES/DEPTH steps.
// Assumes FILL_CYCLES is a multiple of DEPTH and POLY keeps the state nonzero.
module rng_entropy_src #(
    parameter int unsigned W           = 32,
    parameter int unsigned DEPTH       = 4,
    parameter int unsigned FILL_CYCLES = 16,
    parameter logic [W-1:0] POLY       = 32'h8020_0003,
    parameter logic [W-1:0] SEED       = 32'h1ACE_B00C
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_i,
    input  logic         abort_i,
    input  logic         buf_empty_i,
    output logic         push_o,
    output logic [W-1:0] word_o
);
    localparam int unsigned STEP = FILL_CYCLES / DEPTH;
    localparam int unsigned FC_W = $clog2(FILL_CYCLES + 1);
    localparam int unsigned SB_W = $clog2(STEP + 1);

    logic [W-1:0]    lfsr_q, lfsr_nx;
    logic [FC_W-1:0] fill_q;
    logic [SB_W-1:0] sub_q;
    logic            active, step;

    // Next LFSR state, shifting right with the feedback mask.
    always_comb begin
        lfsr_nx = {1'b0, lfsr_q[W-1:1]} ^ (lfsr_q[0] ? POLY : '0);
    end

    assign active = (fill_q != '0) || buf_empty_i;
    assign step   = run_i && active && !abort_i;
    assign push_o = step && (sub_q == SB_W'(STEP - 1));
    assign word_o = lfsr_nx;

    // Advance the LFSR and the refill counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lfsr_q <= SEED;
            fill_q <= '0;
            sub_q  <= '0;
        end else if (abort_i) begin
            fill_q <= '0;
            sub_q  <= '0;
        end else if (step) begin
            lfsr_q <= lfsr_nx;
            fill_q <= (fill_q == FC_W'(FILL_CYCLES - 1)) ? '0 : fill_q + 1'b1;
            sub_q  <= (sub_q == SB_W'(STEP - 1)) ? '0 : sub_q + 1'b1;
        end
    end
endmodule

// File: rtl/rng_outbuf.sv
// Output word FIFO. Ready rises when the FIFO fills and falls when it
// empties. A flush empties it at once. Assumes pops occur only while ready.
module rng_outbuf #(
    parameter int unsigned W     = 32,
    parameter int unsigned DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push_i,
    input  logic [W-1:0]               push_data_i,
    input  logic                       pop_i,
    input  logic                       flush_i,
    output logic [W-1:0]               head_o,
    output logic [$clog2(DEPTH+1)-1:0] count_o,
    output logic                       empty_o,
    output logic                       ready_o
);
    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  mem_q [DEPTH];
    logic [PW-1:0] wp_q, rp_q;
    logic [CW-1:0] cnt_q, cnt_nx;
    logic          rdy_q;

    assign cnt_nx = cnt_q + CW'(push_i) - CW'(pop_i);

    // Store pushed words and track pointers, fill level and ready.
    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
            rdy_q <= 1'b0;
        end else begin
            if (push_i) begin
                mem_q[wp_q] <= push_data_i;
                wp_q <= (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
            end
            if (pop_i) rp_q <= (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
            cnt_q <= cnt_nx;
            if (cnt_nx == CW'(DEPTH)) rdy_q <= 1'b1;
            else if (cnt_nx == '0)    rdy_q <= 1'b0;
        end
    end

    assign head_o  = mem_q[rp_q];
    assign count_o = cnt_q;
    assign empty_o = (cnt_q == '0);
    assign ready_o = rdy_q;
endmodule

// File: rtl/rng_ht_reg.sv
// Magic-locked health-test setting. A magic write unlocks only the next bus
// access. An unlocked write lands only during conditioning, and a locked read
// yields zero.
module rng_ht_reg #(
    parameter int unsigned W    = 32,
    parameter logic [W-1:0] MAGIC = 32'h1759_0ABC,
    parameter logic [W-1:0] INIT  = 32'h0000_72A5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         any_acc_i,
    input  logic         sel_i,
    input  logic         we_i,
    input  logic [W-1:0] wdata_i,
    input  logic         cond_active_i,
    output logic [W-1:0] rd_val_o,
    output logic [W-1:0] ht_o
);
    logic         unlk_q;
    logic [W-1:0] ht_q;

    // Arm the unlock on a locked magic write; any access consumes it.
    always_ff @(posedge clk) begin
        if (!rst_n)         unlk_q <= 1'b0;
        else if (any_acc_i) unlk_q <= sel_i && we_i && !unlk_q && (wdata_i == MAGIC);
    end

    // Store an unlocked write made while conditioning is active.
    always_ff @(posedge clk) begin
        if (!rst_n) ht_q <= INIT;
        else if (any_acc_i && sel_i && we_i && unlk_q && cond_active_i) ht_q <= wdata_i;
    end

    assign rd_val_o = unlk_q ? ht_q : '0;
    assign ht_o     = ht_q;
endmodule

// File: rtl/rng_regctl.sv
// Register controller of the random number peripheral: bus decode, control
// and status registers, fault flags, interrupt and data path. Assumes one
// bus access per cycle and pulse-style fault inputs.
module rng_regctl
    import rng_regctl_pkg::*;
#(
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned BUF_DEPTH   = 4,
    parameter int unsigned FILL_CYCLES = 16,
    parameter int unsigned COND_LAT    = 4,
    parameter logic [31:0] LFSR_POLY   = 32'h8020_0003,
    parameter logic [31:0] LFSR_SEED   = 32'h1ACE_B00C,
    parameter logic [31:0] HT_MAGIC    = 32'h1759_0ABC,
    parameter logic [31:0] HT_INIT     = 32'h0000_72A5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o,
    input  logic              seed_fault_i,
    input  logic              clk_fault_i
);
    localparam int unsigned CNT_W = $clog2(BUF_DEPTH + 1);

    logic             gen_en_q, ie_q, ced_q, cond_req_q;
    logic [CFG_W-1:0] cfg_q;
    logic             clk_flag_q, seed_flag_q, seed_now_q;
    logic [DATA_W-1:0] rdata_q;

    cond_state_e      cond_state;
    logic             cond_rb, cond_active, cond_done;
    logic             wr_ctrl, wr_stat, rd_acc, pop, flush, can_gen;
    logic             push, buf_empty, rdy;
    logic [DATA_W-1:0] push_word, head, ht_rd, ht_val;
    logic [CNT_W-1:0] buf_count;
    logic [DATA_W-1:0] ctrl_rb, stat_rb;

    assign wr_ctrl = bus_en && bus_we && (bus_addr == A_CTRL);
    assign wr_stat = bus_en && bus_we && (bus_addr == A_STAT);
    assign rd_acc  = bus_en && !bus_we;
    assign pop     = rd_acc && (bus_addr == A_DATA) && rdy;
    assign flush   = seed_fault_i || (cond_state != CS_IDLE);
    assign can_gen = gen_en_q && !seed_now_q && (cond_state == CS_IDLE);

    rng_cond_fsm #(.LAT(COND_LAT)) u_cond (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (cond_req_q),
        .state_o  (cond_state),
        .rb_o     (cond_rb),
        .active_o (cond_active),
        .done_o   (cond_done)
    );

    rng_entropy_src #(
        .W(DATA_W), .DEPTH(BUF_DEPTH), .FILL_CYCLES(FILL_CYCLES),
        .POLY(LFSR_POLY), .SEED(LFSR_SEED)
    ) u_src (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_i       (can_gen),
        .abort_i     (flush),
        .buf_empty_i (buf_empty),
        .push_o      (push),
        .word_o      (push_word)
    );

    rng_outbuf #(.W(DATA_W), .DEPTH(BUF_DEPTH)) u_buf (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (push),
        .push_data_i (push_word),
        .pop_i       (pop),
        .flush_i     (flush),
        .head_o      (head),
        .count_o     (buf_count),
        .empty_o     (buf_empty),
        .ready_o     (rdy)
    );

    rng_ht_reg #(.W(DATA_W), .MAGIC(HT_MAGIC), .INIT(HT_INIT)) u_ht (
        .clk           (clk),
        .rst_n         (rst_n),
        .any_acc_i     (bus_en),
        .sel_i         (bus_addr == A_HTST),
        .we_i          (bus_we),
        .wdata_i       (bus_wdata),
        .cond_active_i (cond_active),
        .rd_val_o      (ht_rd),
        .ht_o          (ht_val)
    );

    // Control register; configuration only lands with the conditioning bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gen_en_q   <= 1'b0;
            ie_q       <= 1'b0;
            ced_q      <= 1'b0;
            cond_req_q <= 1'b0;
            cfg_q      <= '0;
        end else if (wr_ctrl) begin
            gen_en_q   <= bus_wdata[CB_EN];
            ie_q       <= bus_wdata[CB_IE];
            ced_q      <= bus_wdata[CB_CED];
            cond_req_q <= bus_wdata[CB_COND];
            if (bus_wdata[CB_COND]) cfg_q <= bus_wdata[CFG_LSB +: CFG_W];
        end
    end

    // Fault flags with their separate set and clear rules.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_flag_q  <= 1'b0;
            seed_flag_q <= 1'b0;
            seed_now_q  <= 1'b0;
        end else begin
            if (clk_fault_i && !ced_q)               clk_flag_q <= 1'b1;
            else if (wr_stat && !bus_wdata[SB_CLK])  clk_flag_q <= 1'b0;
            if (seed_fault_i)                  seed_flag_q <= 1'b1;
            else if (cond_state == CS_ENTER)   seed_flag_q <= 1'b0;
            if (seed_fault_i)   seed_now_q <= 1'b1;
            else if (cond_done) seed_now_q <= 1'b0;
        end
    end

    always_comb begin
        ctrl_rb = '0;
        ctrl_rb[CB_EN]   = gen_en_q;
        ctrl_rb[CB_IE]   = ie_q;
        ctrl_rb[CB_CED]  = ced_q;
        ctrl_rb[CB_COND] = cond_rb;
        ctrl_rb[CFG_LSB +: CFG_W] = cfg_q;
        stat_rb = {{(DATA_W-4){1'b0}}, seed_now_q, seed_flag_q, clk_flag_q, rdy};
    end

    // Registered read data mux.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else if (rd_acc) begin
            unique case (bus_addr)
                A_CTRL:  rdata_q <= ctrl_rb;
                A_STAT:  rdata_q <= stat_rb;
                A_DATA:  rdata_q <= rdy ? head : '0;
                default: rdata_q <= ht_rd;
            endcase
        end
    end

    assign bus_rdata = rdata_q;
    assign irq_o     = ie_q && (rdy || clk_flag_q || seed_flag_q);
endmodule

// File: rtl/rng_regctl_chk.sv
// Property checker for rng_regctl, attached by bind. Observes only.
module rng_regctl_chk #(
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned BUF_DEPTH = 4
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         seed_fault_i,
    input logic                         clk_fault_i,
    input logic                         ced_q,
    input logic                         ie_q,
    input logic                         rdy,
    input logic                         seed_now_q,
    input logic                         seed_flag_q,
    input logic                         clk_flag_q,
    input logic                         cond_active,
    input logic [DATA_W-1:0]            ht_val,
    input logic [$clog2(BUF_DEPTH+1)-1:0] buf_count,
    input logic [DATA_W-1:0]            head,
    input logic                         irq_o
);
    // R11
    seed_fault_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seed_fault_i |=> (!rdy && seed_now_q && seed_flag_q));
    // R10
    clk_fault_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_fault_i && !ced_q) |=> clk_flag_q);
    // R9
    ht_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ht_val != $past(ht_val)) |-> $past(cond_active));
    // R4
    ready_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy) |-> (buf_count == ($clog2(BUF_DEPTH+1))'(BUF_DEPTH)));
    // R6
    nonzero_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rdy |-> (head != '0));
    // R7
    irq_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ie_q);
endmodule

bind rng_regctl rng_regctl_chk #(.DATA_W(DATA_W), .BUF_DEPTH(BUF_DEPTH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .seed_fault_i (seed_fault_i),
    .clk_fault_i  (clk_fault_i),
    .ced_q        (ced_q),
    .ie_q         (ie_q),
    .rdy          (rdy),
    .seed_now_q   (seed_now_q),
    .seed_flag_q  (seed_flag_q),
    .clk_flag_q   (clk_flag_q),
    .cond_active  (cond_active),
    .ht_val       (ht_val),
    .buf_count    (buf_count),
    .head         (head),
    .irq_o        (irq_o)
);

// File: tb/rng_regctl_tb_top.sv
`timescale 1ns/1ps
module rng_regctl_tb_top;
    localparam logic [31:0] MAGIC    = 32'h1759_0ABC;
    localparam logic [31:0] POLY     = 32'h8020_0003;
    localparam logic [31:0] SEED     = 32'h1ACE_B00C;
    localparam logic [31:0] CTRL_CW  = 32'h0002_A5CB; // cfg 0x2A5C, cond, ie, en
    localparam logic [31:0] CTRL_RUN = 32'h0000_0003;

    // {we, addr[1:0], check, wdata, expected}
    localparam logic [67:0] VEC [11] = '{
        {1'b1, 2'd3, 1'b0, MAGIC,         32'h0},
        {1'b0, 2'd3, 1'b1, 32'h0,         32'h0000_72A5},
        {1'b0, 2'd3, 1'b1, 32'h0,         32'h0},
        {1'b1, 2'd3, 1'b0, 32'hDEAD_0001, 32'h0},
        {1'b1, 2'd3, 1'b0, MAGIC,         32'h0},
        {1'b1, 2'd3, 1'b0, 32'h0BAD_F00D, 32'h0},
        {1'b1, 2'd3, 1'b0, MAGIC,         32'h0},
        {1'b0, 2'd0, 1'b1, 32'h0,         CTRL_CW},
        {1'b0, 2'd3, 1'b1, 32'h0,         32'h0},
        {1'b1, 2'd3, 1'b0, MAGIC,         32'h0},
        {1'b0, 2'd3, 1'b1, 32'h0,         32'h0BAD_F00D}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0, bus_we = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;
    logic        seed_fault_i = 1'b0, clk_fault_i = 1'b0;

    int          n_run = 0, n_fail = 0;
    logic [31:0] m_lfsr = SEED;
    logic [31:0] exp_w [4];
    logic [31:0] rd;

    always #2.5 clk = ~clk;

    rng_regctl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .seed_fault_i(seed_fault_i), .clk_fault_i(clk_fault_i)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_en = 1'b0;
        d = bus_rdata;
    endtask

    task automatic pulse(input bit seed);
        @(negedge clk);
        if (seed) seed_fault_i = 1'b1; else clk_fault_i = 1'b1;
        @(negedge clk);
        seed_fault_i = 1'b0; clk_fault_i = 1'b0;
    endtask

    // Model of R4: 16 steps, capture every 4th next state.
    task automatic model_batch();
        for (int k = 0; k < 16; k++) begin
            m_lfsr = {1'b0, m_lfsr[31:1]} ^ (m_lfsr[0] ? POLY : 32'h0);
            if (k % 4 == 3) exp_w[k / 4] = m_lfsr;
        end
    endtask

    task automatic wait_ready(input string req);
        logic [31:0] s;
        s = '0;
        for (int k = 0; k < 60 && !s[0]; k++) bus_read(2'd1, s);
        chk(req, {31'b0, s[0]}, 32'h1);
    endtask

    task automatic read_batch(input string req);
        for (int k = 0; k < 4; k++) begin
            bus_read(2'd2, rd);
            chk(req, rd, exp_w[k]);
            n_run++;
            if (rd == 32'h0) begin
                n_fail++;
                $display("FAIL R6: actual 0x%08h expected nonzero", rd);
            end
        end
    endtask

    task automatic poll_cond(input logic want);
        logic [31:0] c;
        c = {28'b0, ~want, 3'b0};
        for (int k = 0; k < 30 && (c[3] != want); k++) bus_read(2'd0, c);
        chk("R3", {31'b0, c[3]}, {31'b0, want});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        bus_read(2'd0, rd); chk("R1", rd, 32'h0);
        bus_read(2'd1, rd); chk("R1", rd, 32'h0);
        bus_read(2'd2, rd); chk("R1", rd, 32'h0);
        bus_read(2'd3, rd); chk("R8", rd, 32'h0);
        chk("R7", {31'b0, irq_o}, 32'h0);

        // R4 ready due exactly 16 edges after the enabling write
        bus_write(2'd0, CTRL_RUN);
        repeat (15) @(negedge clk);
        chk("R4", {31'b0, irq_o}, 32'h0);
        @(negedge clk);
        chk("R4", {31'b0, irq_o}, 32'h1);
        model_batch();
        read_batch("R5");
        bus_read(2'd1, rd); chk("R5", rd, 32'h0);
        bus_read(2'd2, rd); chk("R5", rd, 32'h0);

        // R10 clock fault during refill; generation continues
        pulse(1'b0);
        bus_read(2'd1, rd); chk("R10", rd, 32'h2);
        chk("R7", {31'b0, irq_o}, 32'h1);
        wait_ready("R10");
        model_batch();
        read_batch("R10");
        wait_ready("R4");
        bus_write(2'd1, 32'h2);
        bus_read(2'd1, rd); chk("R10", rd, 32'h3);
        bus_write(2'd1, 32'h0);
        bus_read(2'd1, rd); chk("R10", rd, 32'h1);
        bus_write(2'd0, 32'h7);
        pulse(1'b0);
        bus_read(2'd1, rd); chk("R10", rd, 32'h1);
        bus_write(2'd0, CTRL_RUN);
        model_batch(); // batch lost to the flush below

        // R11 seed fault
        pulse(1'b1);
        bus_read(2'd1, rd); chk("R11", rd, 32'hC);
        chk("R7", {31'b0, irq_o}, 32'h1);
        bus_read(2'd2, rd); chk("R11", rd, 32'h0);
        repeat (40) @(negedge clk);
        bus_read(2'd1, rd); chk("R11", rd, 32'hC);

        // R3 / R2 conditioning entry
        bus_write(2'd0, CTRL_CW);
        bus_read(2'd0, rd); chk("R3", rd, CTRL_CW & ~32'h8);
        poll_cond(1'b1);
        bus_read(2'd0, rd); chk("R2", rd, CTRL_CW);
        bus_read(2'd1, rd); chk("R12", rd, 32'h8);

        // R8 / R9 health-test lock table
        for (int i = 0; i < 11; i++) begin
            logic [67:0] v;
            v = VEC[i];
            if (v[67]) bus_write(v[66:65], v[63:32]);
            else begin
                bus_read(v[66:65], rd);
                if (v[64]) chk("R8", rd, v[31:0]);
            end
        end

        // R3 / R2 leave conditioning; config in this write is ignored
        bus_write(2'd0, CTRL_RUN);
        poll_cond(1'b0);
        bus_read(2'd0, rd); chk("R2", rd, CTRL_CW & ~32'h8);
        bus_read(2'd1, rd); chk("R12", rd, 32'h0);

        // R9 write outside conditioning is ignored
        bus_write(2'd3, MAGIC);
        bus_write(2'd3, 32'h1111_1111);
        bus_write(2'd3, MAGIC);
        bus_read(2'd3, rd); chk("R9", rd, 32'h0BAD_F00D);

        // R12 generation resumes
        wait_ready("R12");
        model_batch();
        read_batch("R12");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule